// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a clocked 2048 x 8 memory with two fully independent ports, called left and right. Each port can read or write any location in any cycle. Each port has a chip select, an output enable, a write select, an address, write data and registered read data.

The two highest addresses also act as mailboxes between the ports. Address 0x7FE is the left side's mailbox and 0x7FF is the right side's mailbox. When one side writes the other side's mailbox, it raises an interrupt flag on the other side. The receiving side drops its flag by accessing its own mailbox with chip select and output enable both high. The 8-bit message in each mailbox is ordinary memory data. A configuration input, `irq_en`, turns the mailbox function on or off.

Each port takes a plain single-cycle command. There is no valid/ready handshake and no back-pressure: every command with chip select high is accepted in the cycle it is presented. The block does not arbitrate contention between the ports. When both ports write the same address in the same cycle, a fixed rule decides which write is kept (see R3).

Top module: `mbox_dpram`

## Requirements
- R1: A port command with `cs`=1 and `we`=0 reads the addressed location. The data appears on that port's `rdata` one clock after the command. In any cycle where the port does not read, `rdata` keeps its previous value.
- R2: A read presented in the same cycle as a write to the same address from the other port returns the contents from before that write.
- R3: When both ports write the same address in the same cycle, the left port's data is stored.
- R4: With `irq_en`=1, a right-port write (`r_cs`=1, `r_we`=1) to address 0x7FE sets `l_irq` to 1 one clock later.
- R5: `l_irq` is cleared one clock after a left-port access to 0x7FE with `l_cs`=1 and `l_oe`=1, whatever the value of `l_we`. The same access with `l_oe`=0 leaves the flag set.
- R6: With `irq_en`=1, a left-port write to 0x7FF sets `r_irq` one clock later. A right-port access to 0x7FF with `r_cs`=1 and `r_oe`=1 clears it one clock later.
- R7: The data held at 0x7FE and 0x7FF is stored and read back like the data at any other address.
- R8: A port with `cs`=0 performs no access. It writes nothing, and it neither sets nor clears any flag.
- R9: If a flag's set and its clear occur in the same cycle, the flag is 1 afterwards.
- R10: While `irq_en`=0, both flags are 0 from the next clock on, and mailbox writes set nothing.
- R11: A synchronous reset (`rst`=1) makes both flags 0 and both `rdata` outputs 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_en | input | 1 | Enables the mailbox interrupt function |
| l_cs | input | 1 | Left chip select, active high |
| l_oe | input | 1 | Left output enable, active high |
| l_we | input | 1 | Left write select (1 = write, 0 = read) |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, registered |
| l_irq | output | 1 | Left interrupt flag, active high |
| r_cs | input | 1 | Right chip select, active high |
| r_oe | input | 1 | Right output enable, active high |
| r_we | input | 1 | Right write select (1 = write, 0 = read) |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, registered |
| r_irq | output | 1 | Right interrupt flag, active high |

## Verification
Every result is due exactly one clock after its command.
- Read data is due on the edge after the read is presented.
- A flag set or clear is visible on the edge after the triggering access.
- Disabling `irq_en` takes effect on the next edge.

The bench drives each command just after a falling edge and lets one rising edge pass. It samples on the following falling edge, so each check sees the first cycle in which the result is due. For the cases where nothing should happen (a deselected port, `oe` low, mailbox function off), the bench re-reads through the ports in the next cycle. It checks that the stored data and the flags are unchanged.

// File: rtl/mbox_dpram_pkg.sv
package mbox_dpram_pkg;
  parameter int unsigned DEF_ADDR_W = 11;
  parameter int unsigned DEF_DATA_W = 8;

  typedef enum logic {SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1} side_e;
endpackage

// File: rtl/dpram_core.sv
module dpram_core #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             cs_i,
  input  logic [1:0]             we_i,
  input  logic [1:0][ADDR_W-1:0] addr_i,
  input  logic [1:0][DATA_W-1:0] wdata_i,
  output logic [1:0][DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [1:0]        wr;
  logic [1:0]        rd;

  always_comb begin
    wr = cs_i & we_i;
    rd = cs_i & ~we_i;
  end

  // Index 0 is the left port. Its write is applied last, so it wins a tie.
  always_ff @(posedge clk) begin
    if (wr[1]) mem[addr_i[1]] <= wdata_i[1];
    if (wr[0]) mem[addr_i[0]] <= wdata_i[0];
  end

  for (genvar g = 0; g < 2; g++) begin : g_rd
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (rd[g]) q <= mem[addr_i[g]];
    end
    assign rdata_o[g] = q;

    // R1
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rd[g] |=> $stable(rdata_o[g]));
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
  import mbox_dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter side_e       OWNER  = SIDE_LEFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              own_cs,
  input  logic              own_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              peer_cs,
  input  logic              peer_we,
  input  logic [ADDR_W-1:0] peer_addr,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] BOX =
    (OWNER == SIDE_LEFT) ? {{(ADDR_W-1){1'b1}}, 1'b0} : {ADDR_W{1'b1}};

  logic set_ev, clr_ev, irq_q;

  always_comb begin
    set_ev = peer_cs && peer_we && (peer_addr == BOX);
    clr_ev = own_cs && own_oe && (own_addr == BOX);
  end

  always_ff @(posedge clk) begin
    if (rst || !en)  irq_q <= 1'b0;
    else if (set_ev) irq_q <= 1'b1;
    else if (clr_ev) irq_q <= 1'b0;
  end
  assign irq = irq_q;

  // R4
  set_takes_chk: assert property (@(posedge clk) disable iff (rst)
    en && peer_cs && peer_we && peer_addr == BOX |=> irq);
  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    en && own_cs && own_oe && own_addr == BOX && !(peer_cs && peer_we && peer_addr == BOX) |=> !irq);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    en && !own_cs && !peer_cs |=> $stable(irq));
  // R10
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_en,
  input  logic              l_cs,
  input  logic              l_oe,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq,
  input  logic              r_cs,
  input  logic              r_oe,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq
);
  logic [1:0][DATA_W-1:0] rdata;

  dpram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .cs_i    ({r_cs, l_cs}),
    .we_i    ({r_we, l_we}),
    .addr_i  ({r_addr, l_addr}),
    .wdata_i ({r_wdata, l_wdata}),
    .rdata_o (rdata)
  );
  assign l_rdata = rdata[0];
  assign r_rdata = rdata[1];

  mbox_flag #(.ADDR_W(ADDR_W), .OWNER(SIDE_LEFT)) u_flag_l (
    .clk(clk), .rst(rst), .en(irq_en),
    .own_cs(l_cs), .own_oe(l_oe), .own_addr(l_addr),
    .peer_cs(r_cs), .peer_we(r_we), .peer_addr(r_addr),
    .irq(l_irq)
  );

  mbox_flag #(.ADDR_W(ADDR_W), .OWNER(SIDE_RIGHT)) u_flag_r (
    .clk(clk), .rst(rst), .en(irq_en),
    .own_cs(r_cs), .own_oe(r_oe), .own_addr(r_addr),
    .peer_cs(l_cs), .peer_we(l_we), .peer_addr(l_addr),
    .irq(r_irq)
  );

  // R11
  reset_flags_chk: assert property (@(posedge clk)
    rst |=> !l_irq && !r_irq);
endmodule

// File: tb/mbox_dpram_bench.sv
module mbox_dpram_bench;
  logic clk = 1'b0;
  logic rst, irq_en;
  logic l_cs, l_oe, l_we, r_cs, r_oe, r_we;
  logic [10:0] l_addr, r_addr;
  logic [7:0]  l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_irq, r_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mbox_dpram u_mbox_dpram (.*);

  // Each entry: [19] writer side (0 = left), [18:8] address, [7:0] data.
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 11'h000, 8'h5C}, {1'b1, 11'h7FD, 8'hA3},
    {1'b0, 11'h123, 8'h0F}, {1'b1, 11'h400, 8'hF0},
    {1'b0, 11'h7FE, 8'h96}, {1'b1, 11'h7FF, 8'h69}};

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_cs = 0; l_oe = 0; l_we = 0; r_cs = 0; r_oe = 0; r_we = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic lcmd(input logic cs, oe, we, input logic [10:0] a, input logic [7:0] d);
    l_cs = cs; l_oe = oe; l_we = we; l_addr = a; l_wdata = d;
  endtask

  task automatic rcmd(input logic cs, oe, we, input logic [10:0] a, input logic [7:0] d);
    r_cs = cs; r_oe = oe; r_we = we; r_addr = a; r_wdata = d;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    idle(); rst = 1; irq_en = 0; l_addr = 0; r_addr = 0; l_wdata = 0; r_wdata = 0;
    step(); step();
    chk({7'd0, l_irq}, 8'd0, "R11 l_irq"); chk({7'd0, r_irq}, 8'd0, "R11 r_irq");
    chk(l_rdata, 8'd0, "R11 l_rdata"); chk(r_rdata, 8'd0, "R11 r_rdata");
    rst = 0;

    // Table walk with mailbox function off: write on one side, read on the other (R1, R7, R10).
    foreach (VEC[i]) begin
      idle();
      if (VEC[i][19]) rcmd(1, 0, 1, VEC[i][18:8], VEC[i][7:0]);
      else            lcmd(1, 0, 1, VEC[i][18:8], VEC[i][7:0]);
      step(); idle();
      if (VEC[i][19]) begin
        lcmd(1, 1, 0, VEC[i][18:8], 8'h00); step();
        chk(l_rdata, VEC[i][7:0], "R1/R7 table left read");
      end else begin
        rcmd(1, 1, 0, VEC[i][18:8], 8'h00); step();
        chk(r_rdata, VEC[i][7:0], "R1/R7 table right read");
      end
      chk({6'd0, l_irq, r_irq}, 8'd0, "R10 flags stay low");
    end

    idle(); irq_en = 1;
    lcmd(1, 0, 1, 11'h010, 8'h33); step(); idle();
    // R8: a deselected write stores nothing
    lcmd(0, 1, 1, 11'h010, 8'hEE); step(); idle();

    // R4
    rcmd(1, 0, 1, 11'h7FE, 8'h5A); step(); idle();
    chk({7'd0, l_irq}, 8'd1, "R4 l_irq set");
    chk({7'd0, r_irq}, 8'd0, "R4 r_irq untouched");
    // R8: a deselected access does not clear
    lcmd(0, 1, 0, 11'h7FE, 8'h00); step(); idle();
    chk({7'd0, l_irq}, 8'd1, "R8 cs low no clear");
    // R5: no clear while oe is low; mailbox data readable (R7)
    lcmd(1, 0, 0, 11'h7FE, 8'h00); step(); idle();
    chk({7'd0, l_irq}, 8'd1, "R5 oe low keeps flag");
    chk(l_rdata, 8'h5A, "R7 mailbox 7FE data");
    // R5: a write with cs and oe high clears, we is ignored
    lcmd(1, 1, 1, 11'h7FE, 8'h77); step(); idle();
    chk({7'd0, l_irq}, 8'd0, "R5 clear on access");

    // R6
    lcmd(1, 0, 1, 11'h7FF, 8'h3C); step(); idle();
    chk({7'd0, r_irq}, 8'd1, "R6 r_irq set");
    rcmd(1, 1, 0, 11'h7FF, 8'h00); step(); idle();
    chk({7'd0, r_irq}, 8'd0, "R6 r_irq cleared");
    chk(r_rdata, 8'h3C, "R7 mailbox 7FF data");

    // R9: set and clear together, set wins
    rcmd(1, 0, 1, 11'h7FE, 8'h01); step(); idle();
    rcmd(1, 0, 1, 11'h7FE, 8'h02); lcmd(1, 1, 0, 11'h7FE, 8'h00); step(); idle();
    chk({7'd0, l_irq}, 8'd1, "R9 set beats clear");
    lcmd(1, 1, 0, 11'h7FE, 8'h00); step(); idle();
    chk({7'd0, l_irq}, 8'd0, "R9 later clear");

    // R10: disabling drops a raised flag and blocks new sets
    lcmd(1, 0, 1, 11'h7FF, 8'h44); step(); idle();
    chk({7'd0, r_irq}, 8'd1, "R10 pre-set");
    irq_en = 0; step();
    chk({7'd0, r_irq}, 8'd0, "R10 disable drops flag");
    lcmd(1, 0, 1, 11'h7FF, 8'h45); step(); idle();
    irq_en = 1; step();
    chk({7'd0, r_irq}, 8'd0, "R10 write while off sets nothing");

    // R3: both ports write one address, left wins
    lcmd(1, 0, 1, 11'h055, 8'hA1); rcmd(1, 0, 1, 11'h055, 8'hB2); step(); idle();
    lcmd(1, 1, 0, 11'h055, 8'h00); rcmd(1, 1, 0, 11'h055, 8'h00); step(); idle();
    chk(l_rdata, 8'hA1, "R3 left view"); chk(r_rdata, 8'hA1, "R3 right view");

    // R2: read during a write from the other side returns the old data
    lcmd(1, 0, 1, 11'h066, 8'h11); step(); idle();
    lcmd(1, 0, 1, 11'h066, 8'h22); rcmd(1, 1, 0, 11'h066, 8'h00); step(); idle();
    chk(r_rdata, 8'h11, "R2 old data");
    rcmd(1, 1, 0, 11'h066, 8'h00); step(); idle();
    chk(r_rdata, 8'h22, "R2 new data next read");

    // R1: rdata holds while the port does not read
    step();
    chk(r_rdata, 8'h22, "R1 hold right");
    rcmd(1, 0, 1, 11'h067, 8'h99); step(); idle();
    chk(r_rdata, 8'h22, "R1 hold through write");

    // R8: the deselected write left 0x010 intact
    lcmd(1, 1, 0, 11'h010, 8'h00); step(); idle();
    chk(l_rdata, 8'h33, "R8 no store when deselected");

    done = 1'b1;
    finish_run();
  end
endmodule